// File: doc/BRIEF.md
# Clock-Detect Power-Up Calibration Sequencer

This block brings an oversampling converter core out of power-down in a controlled order. It runs from a free-running reference clock and watches two incoming clocks: a master clock and a frame clock. Both are sampled and synchronized into the reference domain. While either clock is missing, the sequencer holds the core in power-down. In that state the analog supply enable is low and the filter/modulator reset is high.

Once both clocks toggle, the sequencer waits for a frame boundary. It then counts master-clock rising edges over one full frame period and keeps that count as the clock ratio. Only a ratio from a set of three supported values lets the sequence continue. With a supported ratio, analog power comes on and a calibration phase runs for a fixed number of frames before the core enters the run state. If either clock stops, the sequencer drops back to power-down and repeats the whole sequence when the clocks return.

Two format-select pins are also watched. When they take a new value and hold it for a set number of frames while the core is powered, an offset recalibration of the same length is started. Shorter changes are filtered out.

Top module: `pwrup_cal_seq`

## Requirements
- R1: After reset the outputs are pwr_en=0, flt_rst=1, cal_busy=0 and ratio=0.
- R2: While only one of the two clocks toggles, pwr_en stays 0 and flt_rst stays 1.
- R3: The ratio output equals the number of master-clock rising edges counted between two consecutive frame-clock rising edges, and it is held through calibration and run.
- R4: With a supported ratio (RATIO_A, RATIO_B or RATIO_C), cal_busy and pwr_en are 1 and flt_rst is 0 for exactly CAL_FRAMES frame periods. After that cal_busy is 0 and pwr_en stays 1 (run).
- R5: With any other ratio, pwr_en never rises, flt_rst stays 1 and ratio reads 0.
- R6: When either clock stops, pwr_en falls and flt_rst rises within MISS_LIMIT+6 reference cycles. The full sequence repeats when both clocks return.
- R7: A change of fmt_sel during calibration or run that holds for FMT_HOLD frame rising edges starts a recalibration. cal_busy rises between 2 and 3 frame periods (+6 cycles) after the change, for FMT_HOLD=3, and lasts CAL_FRAMES frames.
- R8: A fmt_sel change that reverts before FMT_HOLD frame edges starts no recalibration. A further new value restarts the frame count.
- R9: fmt_sel changes made while powered down never cause a recalibration later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_in | input | 1 | Master clock, sampled in the reference domain |
| fclk_in | input | 1 | Frame clock, sampled in the reference domain |
| fmt_sel | input | FMT_W | Data-format select pins |
| pwr_en | output | 1 | Analog power enable |
| flt_rst | output | 1 | Filter and modulator reset |
| cal_busy | output | 1 | Calibration or recalibration in progress |
| ratio | output | RATIO_W | Measured master-to-frame ratio, 0 when not powered |

## Verification
Assertions check the following every cycle:
- A loss of either clock forces power-down on the next cycle.
- A powered state always holds a supported ratio.
- The run state is only reached from calibration.
- A clock edge always marks that clock present.
- The recalibration request is a single-cycle pulse.

Other properties span many frames and can only be shown by the bench scenarios:
- the exact calibration length,
- the ratio value measured for each frame length,
- the time to detect a stopped clock,
- the filtering of short format changes and the restart of the count on a new value.

These scenarios run over several random frame lengths, both supported and unsupported.

// File: rtl/pwrup_cal_pkg.sv
package pwrup_cal_pkg;

    typedef enum logic [2:0] {
        ST_PDN   = 3'd0,
        ST_ALIGN = 3'd1,
        ST_MEAS  = 3'd2,
        ST_CAL   = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_t;

    localparam int unsigned NUM_CLK = 2;
    localparam int unsigned IDX_MCLK = 0;
    localparam int unsigned IDX_FCLK = 1;

    function automatic logic ratio_in_set(input int unsigned r,
                                          input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c);
        return (r == a) || (r == b) || (r == c);
    endfunction

endpackage

// File: rtl/clk_presence_mon.sv
module clk_presence_mon #(
    parameter int unsigned MISS_LIMIT = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic present
);
    localparam int unsigned CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MISS_LIMIT);

    logic [2:0]    sync_q;
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            idle_cnt <= LIMIT;
        end else begin
            sync_q <= {sync_q[1:0], pin};
            if (rise)
                idle_cnt <= '0;
            else if (idle_cnt != LIMIT)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign rise    = sync_q[1] & ~sync_q[2];
    assign present = (idle_cnt != LIMIT);

    assert_present_after_edge_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> present);

endmodule

// File: rtl/fmt_change_filter.sv
module fmt_change_filter #(
    parameter int unsigned FMT_W    = 2,
    parameter int unsigned FMT_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FMT_W-1:0] fmt_pin,
    input  logic             frame_rise,
    input  logic             track,
    output logic             recal_req
);
    localparam int unsigned HW = $clog2(FMT_HOLD + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(FMT_HOLD - 1);

    logic [FMT_W-1:0] s1_q, s2_q, committed_q, cand_q;
    logic [HW-1:0]    hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q        <= '0;
            s2_q        <= '0;
            committed_q <= '0;
            cand_q      <= '0;
            hold_cnt    <= '0;
            recal_req   <= 1'b0;
        end else begin
            s1_q      <= fmt_pin;
            s2_q      <= s1_q;
            recal_req <= 1'b0;
            if (track) begin
                committed_q <= s2_q;
                cand_q      <= s2_q;
                hold_cnt    <= '0;
            end else if (s2_q == committed_q) begin
                cand_q   <= s2_q;
                hold_cnt <= '0;
            end else if (s2_q != cand_q) begin
                cand_q   <= s2_q;
                hold_cnt <= '0;
            end else if (frame_rise) begin
                if (hold_cnt == HOLD_LAST) begin
                    committed_q <= cand_q;
                    hold_cnt    <= '0;
                    recal_req   <= 1'b1;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

    assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
        recal_req |=> !recal_req);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import pwrup_cal_pkg::*;
#(
    parameter int unsigned RATIO_W    = 10,
    parameter int unsigned RATIO_A    = 256,
    parameter int unsigned RATIO_B    = 384,
    parameter int unsigned RATIO_C    = 512,
    parameter int unsigned CAL_FRAMES = 2700
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               m_rise,
    input  logic               m_ok,
    input  logic               f_rise,
    input  logic               f_ok,
    input  logic               recal_req,
    output logic               track,
    output logic               pwr_en,
    output logic               flt_rst,
    output logic               cal_busy,
    output logic [RATIO_W-1:0] ratio
);
    localparam int unsigned CAL_W = $clog2(CAL_FRAMES + 1);
    localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_FRAMES - 1);

    seq_state_t         state;
    logic [RATIO_W-1:0] mcnt, ratio_q, meas_next;
    logic [RATIO_W:0]   meas_sum;
    logic [CAL_W-1:0]   cal_cnt;
    logic               clocks_ok;

    assign clocks_ok = m_ok & f_ok;
    assign meas_sum  = {1'b0, mcnt} + {{RATIO_W{1'b0}}, m_rise};
    assign meas_next = meas_sum[RATIO_W] ? {RATIO_W{1'b1}} : meas_sum[RATIO_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_PDN;
            mcnt    <= '0;
            ratio_q <= '0;
            cal_cnt <= '0;
        end else if (!clocks_ok) begin
            state   <= ST_PDN;
            ratio_q <= '0;
        end else begin
            case (state)
                ST_PDN: begin
                    ratio_q <= '0;
                    state   <= ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (f_rise) begin
                        mcnt  <= '0;
                        state <= ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    if (f_rise) begin
                        if (ratio_in_set(32'(meas_next), RATIO_A, RATIO_B, RATIO_C)) begin
                            ratio_q <= meas_next;
                            cal_cnt <= '0;
                            state   <= ST_CAL;
                        end else begin
                            state <= ST_PDN;
                        end
                    end else begin
                        mcnt <= meas_next;
                    end
                end
                ST_CAL: begin
                    if (recal_req)
                        cal_cnt <= '0;
                    else if (f_rise) begin
                        if (cal_cnt == CAL_LAST)
                            state <= ST_RUN;
                        else
                            cal_cnt <= cal_cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (recal_req) begin
                        cal_cnt <= '0;
                        state   <= ST_CAL;
                    end
                end
                default: state <= ST_PDN;
            endcase
        end
    end

    assign track    = (state == ST_PDN) || (state == ST_ALIGN) || (state == ST_MEAS);
    assign pwr_en   = (state == ST_CAL) || (state == ST_RUN);
    assign flt_rst  = ~pwr_en;
    assign cal_busy = (state == ST_CAL);
    assign ratio    = ratio_q;

    assert_loss_to_pdn_R6: assert property (@(posedge clk) disable iff (rst)
        !clocks_ok |=> (state == ST_PDN));

    assert_powered_ratio_R4: assert property (@(posedge clk) disable iff (rst)
        pwr_en |-> ratio_in_set(32'(ratio_q), RATIO_A, RATIO_B, RATIO_C));

    assert_run_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_CAL));

    assert_pdn_ratio_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PDN && $past(state) == ST_PDN) |-> (ratio_q == '0));

endmodule

// File: rtl/pwrup_cal_seq.sv
module pwrup_cal_seq
    import pwrup_cal_pkg::*;
#(
    parameter int unsigned RATIO_W    = 10,
    parameter int unsigned RATIO_A    = 256,
    parameter int unsigned RATIO_B    = 384,
    parameter int unsigned RATIO_C    = 512,
    parameter int unsigned CAL_FRAMES = 2700,
    parameter int unsigned FMT_W      = 2,
    parameter int unsigned FMT_HOLD   = 3,
    parameter int unsigned MISS_LIMIT = 1200
) (
    input  logic               clk_ref,
    input  logic               rst,
    input  logic               mclk_in,
    input  logic               fclk_in,
    input  logic [FMT_W-1:0]   fmt_sel,
    output logic               pwr_en,
    output logic               flt_rst,
    output logic               cal_busy,
    output logic [RATIO_W-1:0] ratio
);
    logic [NUM_CLK-1:0] pins, rises, oks;
    logic               track, recal_req;

    assign pins[IDX_MCLK] = mclk_in;
    assign pins[IDX_FCLK] = fclk_in;

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_mon
        clk_presence_mon #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
            .clk     (clk_ref),
            .rst     (rst),
            .pin     (pins[g]),
            .rise    (rises[g]),
            .present (oks[g])
        );
    end

    fmt_change_filter #(.FMT_W(FMT_W), .FMT_HOLD(FMT_HOLD)) u_fmt (
        .clk        (clk_ref),
        .rst        (rst),
        .fmt_pin    (fmt_sel),
        .frame_rise (rises[IDX_FCLK]),
        .track      (track),
        .recal_req  (recal_req)
    );

    seq_fsm #(
        .RATIO_W(RATIO_W), .RATIO_A(RATIO_A), .RATIO_B(RATIO_B),
        .RATIO_C(RATIO_C), .CAL_FRAMES(CAL_FRAMES)
    ) u_fsm (
        .clk       (clk_ref),
        .rst       (rst),
        .m_rise    (rises[IDX_MCLK]),
        .m_ok      (oks[IDX_MCLK]),
        .f_rise    (rises[IDX_FCLK]),
        .f_ok      (oks[IDX_FCLK]),
        .recal_req (recal_req),
        .track     (track),
        .pwr_en    (pwr_en),
        .flt_rst   (flt_rst),
        .cal_busy  (cal_busy),
        .ratio     (ratio)
    );

endmodule

// File: tb/pwrup_cal_seq_tb.sv
module pwrup_cal_seq_tb;
    localparam int unsigned CAL = 5;
    localparam int unsigned MISS = 48;
    localparam int unsigned WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0, fclk = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic pwr_en, flt_rst, cal_busy;
    logic [9:0] ratio;

    logic m_run = 1'b0, f_run = 1'b0;
    int fhalf = 8;
    int fcnt = 0;
    int errors = 0, checks = 0, cyc = 0;
    int cal_len = 0, last_len = 0, cal_done = 0, cal_start = 0;
    logic pwr_seen = 1'b0, prev_busy = 1'b0;

    always #5 clk = ~clk;

    pwrup_cal_seq #(
        .RATIO_W(10), .RATIO_A(8), .RATIO_B(12), .RATIO_C(16),
        .CAL_FRAMES(CAL), .FMT_W(2), .FMT_HOLD(3), .MISS_LIMIT(MISS)
    ) u_dut (
        .clk_ref(clk), .rst(rst), .mclk_in(mclk), .fclk_in(fclk), .fmt_sel(fmt),
        .pwr_en(pwr_en), .flt_rst(flt_rst), .cal_busy(cal_busy), .ratio(ratio)
    );

    // stimulus clocks and monitors, away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (m_run) mclk <= ~mclk;
        if (f_run) begin
            if (fcnt >= fhalf - 1) begin fcnt <= 0; fclk <= ~fclk; end
            else fcnt <= fcnt + 1;
        end
        if (!rst) begin
            if (pwr_en) pwr_seen <= 1'b1;
            if (cal_busy) cal_len <= cal_len + 1;
            if (cal_busy && !prev_busy) cal_start <= cal_start + 1;
            if (!cal_busy && prev_busy) begin
                last_len <= cal_len; cal_len <= 0; cal_done <= cal_done + 1;
            end
            prev_busy <= cal_busy;
        end
        if (cyc == WD_LIMIT) begin
            errors = errors + 1; checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic exp_ok(input int h);
        return (h == 8) || (h == 12) || (h == 16);
    endfunction
    function automatic int exp_ratio(input int h);
        return exp_ok(h) ? h : 0;
    endfunction
    function automatic int exp_cal_len(input int h);
        return CAL * 2 * h;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_all();
        int t;
        m_run = 1'b0; f_run = 1'b0;
        t = 0;
        while (pwr_en && t < 400) begin wait_n(1); t++; end
        wait_n(MISS + 10);
    endtask

    task automatic bring_up(input int h);
        int t, d0;
        fhalf = h; fcnt = 0;
        pwr_seen = 1'b0;
        d0 = cal_done;
        m_run = 1'b1; f_run = 1'b1;
        if (exp_ok(h)) begin
            t = 0;
            while (cal_done == d0 && t < 2000) begin wait_n(1); t++; end
            wait_n(2);
            check(last_len == exp_cal_len(h), "R4 cal length", last_len, exp_cal_len(h));
            check(32'(ratio) == exp_ratio(h), "R3 ratio", 32'(ratio), exp_ratio(h));
            check(pwr_en && !flt_rst && !cal_busy, "R4 run outputs", {pwr_en, flt_rst, cal_busy}, 3'b100);
        end else begin
            wait_n(20 * 2 * h);
            check(!pwr_seen, "R5 no power", pwr_seen, 0);
            check(ratio == 0 && flt_rst, "R5 ratio zero", 32'(ratio), 0);
        end
    endtask

    task automatic time_to_cal(output int t);
        int s0;
        s0 = cal_start; t = 0;
        while (cal_start == s0 && t < 1000) begin wait_n(1); t++; end
    endtask

    initial begin
        int t, s0, p, r;
        r = $urandom(32'd20250611);
        wait_n(4);
        check(!pwr_en && flt_rst && !cal_busy && ratio == 0, "R1 reset outputs",
              {pwr_en, flt_rst, cal_busy}, 3'b010);
        rst = 1'b0;
        wait_n(2);
        check(!pwr_en && flt_rst && !cal_busy && ratio == 0, "R1 after reset",
              {pwr_en, flt_rst, cal_busy}, 3'b010);

        // R2: one clock at a time
        m_run = 1'b1; wait_n(300);
        check(!pwr_seen && flt_rst, "R2 master only", pwr_seen, 0);
        m_run = 1'b0; wait_n(MISS + 10);
        fhalf = 8; fcnt = 0; f_run = 1'b1; wait_n(300);
        check(!pwr_seen && flt_rst, "R2 frame only", pwr_seen, 0);
        f_run = 1'b0; wait_n(MISS + 10);

        // directed bring-ups
        bring_up(8);
        p = 16;
        // R7: held format change
        fmt = 2'b01; time_to_cal(t);
        check(t >= 2 * p && t <= 3 * p + 6, "R7 recal delay", t, 3 * p);
        s0 = cal_done; t = 0;
        while (cal_done == s0 && t < 500) begin wait_n(1); t++; end
        wait_n(1);
        check(last_len >= 5 * p - 2 && last_len <= 5 * p, "R7 recal length", last_len, 5 * p);
        // R8: reverting change ignored
        s0 = cal_start;
        fmt = 2'b11; wait_n(p / 2); fmt = 2'b01; wait_n(8 * p);
        check(cal_start == s0, "R8 revert ignored", cal_start - s0, 0);
        // R8: second new value restarts the count
        fmt = 2'b10; wait_n(p); fmt = 2'b00; time_to_cal(t);
        check(t >= 2 * p && t <= 3 * p + 6, "R8 count restart", t, 3 * p);
        wait_n(8 * p);

        // R6: master clock loss
        m_run = 1'b0; t = 0;
        while (pwr_en && t < 400) begin wait_n(1); t++; end
        check(t <= MISS + 6, "R6 master loss time", t, MISS + 6);
        check(flt_rst && ratio == 0, "R6 master loss outputs", flt_rst, 1);
        f_run = 1'b0; wait_n(MISS + 10);
        bring_up(12);
        // R6: frame clock loss
        f_run = 1'b0; t = 0;
        while (pwr_en && t < 400) begin wait_n(1); t++; end
        check(t <= MISS + 6, "R6 frame loss time", t, MISS + 6);
        stop_all();

        // R9: change while powered down
        fmt = 2'b11; wait_n(20);
        bring_up(16);
        s0 = cal_start; wait_n(10 * 32);
        check(cal_start == s0, "R9 no recal after pdn change", cal_start - s0, 0);
        stop_all();

        // unsupported ratio directed
        bring_up(10);
        stop_all();

        // random frame lengths
        for (int i = 0; i < 6; i++) begin
            int pick;
            pick = $urandom % 5;
            fmt = 2'($urandom);
            case (pick)
                0: bring_up(8);
                1: bring_up(12);
                2: bring_up(16);
                3: bring_up(10);
                default: bring_up(20);
            endcase
            stop_all();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule